// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a parameterised set of external interrupt sources and presents them to a parameterised set of targets. A target is one privilege level of one hardware thread, and each target has its own interrupt output. Software sets a priority for each source. For each target it sets a per-source enable mask and a priority threshold. A target's line is raised when its best eligible source has a priority strictly above that target's threshold.

A handler reads its target's claim register. The read returns the winning source ID and takes that source out of circulation. When the handler is done, it writes the same ID back to the same register. Each source has a gateway in front of it. The gateway turns a level input or a rising edge into a single pending request. For edge sources, each source is set separately: edges that arrive while its handler runs are either counted and replayed one at a time after each completion, or thrown away.

Registers are reached through a request port that accepts every request. A read answers exactly one cycle after it is accepted.

Top module: `plic_core`

## Requirements
- R1: After reset all interrupt outputs are low, every configuration register reads 0 and every claim read returns 0.
- R2: The address is split into a region (bits 19:16) and an index (bits 15:0). Region 0 is source priority, indexed by source ID 1..N_SRC. Region 1 is source mode, with bit 0 set for edge trigger and bit 1 set for queue mode. Region 2 is the target enable mask, indexed by target, with bit s enabling source s. Region 3 is the target threshold. Region 4 is target claim (read) and completion (write). Writes are read back unchanged, except that enable bit 0 always reads 0. Every accepted read gives rsp_valid_o exactly one cycle later, and no other event raises it.
- R3: A level-mode source whose input is high becomes pending. A target's line rises once a pending source that the target has enabled has priority above the target's threshold.
- R4: A source with priority 0 never raises a line and is never returned by a claim. A source whose priority equals the threshold does not raise the line.
- R5: A claim read returns the ID of the highest-priority pending source, among those enabled for that target with nonzero priority. On equal priority the lowest ID is returned. The claim read returns 0 when no such source exists. The threshold does not restrict what a claim returns.
- R6: A claim clears the source's pending state. The source stays blocked, so it can neither become pending nor drive a line, until a completion for its ID is accepted. After that, a level source that is still high becomes pending again.
- R7: A completion written by a target for an ID that the target has not enabled, or for ID 0 or an ID above N_SRC, is ignored.
- R8: In edge queue mode, rising edges that arrive while the source is claimed are counted, saturating at 2^QCNT_W-1. Each completion then re-pends the source once and decrements the count.
- R9: In edge ignore mode, rising edges that arrive while the source is claimed are discarded. A completion then leaves the source idle.
- R10: A source drives only the lines of targets that enable it. A source claimed by one target is withheld from all targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | External interrupt inputs; bit s is source ID s |
| irq_o | output | N_CTX | Interrupt line per target |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Region in bits 19:16, index in bits 15:0 |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The hardest state to reach is an edge source whose replay counter is saturated while its ID is still claimed. Only a burst of rising edges during an open claim can put the gateway there, and its only visible trace is how many later completions produce a fresh claimable ID. The stimulus claims a queue-mode source and pulses its input more times than the counter holds. It then alternates completions and claims until the claim returns 0. An ignore-mode sibling with equal priority receives the same treatment in the same window. A behavioural model tracks every gateway, and its predicted lines and read data are compared every cycle.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 16;

    // Register regions selected by the upper address bits
    typedef enum logic [3:0] {
        REG_PRIO   = 4'd0,
        REG_MODE   = 4'd1,
        REG_ENABLE = 4'd2,
        REG_THRESH = 4'd3,
        REG_CLAIM  = 4'd4
    } reg_region_e;

    // Per-source trigger configuration, bit 1 = queue, bit 0 = edge
    typedef struct packed {
        logic queue;
        logic edge_trig;
    } src_mode_t;

    typedef struct packed {
        logic               valid;
        logic               write;
        reg_region_e        region;
        logic [IDX_W-1:0]   index;
        logic [DATA_W-1:0]  wdata;
    } reg_req_t;

    function automatic reg_region_e region_of(input logic [ADDR_W-1:0] a);
        return reg_region_e'(a[ADDR_W-1:IDX_W]);
    endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
#(
    parameter int QCNT_W = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      src_i,
    input  src_mode_t mode_i,
    input  logic      claim_i,
    input  logic      done_i,
    output logic      pend_o,
    output logic      infl_o
);
    localparam logic [QCNT_W-1:0] CNT_MAX = '1;

    logic              pend_q, infl_q, src_q;
    logic [QCNT_W-1:0] cnt_q;
    logic              pend_n, infl_n;
    logic [QCNT_W-1:0] cnt_n;
    logic              rise;

    assign rise = src_i & ~src_q;

    always_comb begin
        pend_n = pend_q;
        infl_n = infl_q;
        cnt_n  = cnt_q;
        // handshake from the targets first
        if (claim_i) begin
            pend_n = 1'b0;
            infl_n = 1'b1;
        end else if (done_i && infl_q) begin
            infl_n = 1'b0;
            if (mode_i.edge_trig && mode_i.queue && cnt_q != '0) begin
                pend_n = 1'b1;
                cnt_n  = cnt_q - 1'b1;
            end
        end
        // then the input event
        if (!mode_i.edge_trig) begin
            if (src_i && !pend_n && !infl_n) pend_n = 1'b1;
        end else if (rise) begin
            if (!pend_n && !infl_n) begin
                pend_n = 1'b1;
            end else if (infl_n && mode_i.queue && cnt_n != CNT_MAX) begin
                cnt_n = cnt_n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            infl_q <= 1'b0;
            src_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            pend_q <= pend_n;
            infl_q <= infl_n;
            src_q  <= src_i;
            cnt_q  <= cnt_n;
        end
    end

    assign pend_o = pend_q;
    assign infl_o = infl_q;

endmodule

// File: rtl/plic_target.sv
module plic_target #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [N_SRC:0][PRIO_W-1:0] prio_i,
    input  logic [N_SRC:0]             pend_i,
    input  logic [N_SRC:0]             en_i,
    input  logic [PRIO_W-1:0]          thr_i,
    output logic [ID_W-1:0]            id_o,
    output logic                       irq_o
);
    logic [PRIO_W-1:0] best_p;

    // strict greater-than keeps the lowest ID on a tie; priority 0 never wins
    always_comb begin
        best_p = '0;
        id_o   = '0;
        for (int s = 0; s <= N_SRC; s++) begin
            if (pend_i[s] && en_i[s] && prio_i[s] > best_p) begin
                best_p = prio_i[s];
                id_o   = ID_W'(s);
            end
        end
        irq_o = best_p > thr_i;
    end

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_CTX  = 2,
    parameter int PRIO_W = 3,
    parameter int QCNT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC:1]    src_i,
    output logic [N_CTX-1:0]  irq_o,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o
);
    localparam int ID_W  = $clog2(N_SRC + 1);
    localparam int CID_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;

    reg_req_t req;
    assign req = '{valid:  req_valid_i,
                   write:  req_write_i,
                   region: region_of(req_addr_i),
                   index:  req_addr_i[IDX_W-1:0],
                   wdata:  req_wdata_i};

    logic [ID_W-1:0]  sidx;
    logic [CID_W-1:0] cidx;
    logic             src_hit, ctx_hit, rd_acc, wr_acc;

    assign sidx    = req.index[ID_W-1:0];
    assign cidx    = req.index[CID_W-1:0];
    assign src_hit = (req.index != '0) && (req.index <= IDX_W'(N_SRC));
    assign ctx_hit = req.index < IDX_W'(N_CTX);
    assign rd_acc  = req.valid && !req.write;
    assign wr_acc  = req.valid && req.write;
    assign req_ready_o = 1'b1;

    // configuration state
    logic      [N_SRC:0][PRIO_W-1:0] prio_q;
    src_mode_t [N_SRC:0]             mode_q;
    logic      [N_CTX-1:0][N_SRC:0]  en_q;
    logic      [N_CTX-1:0][PRIO_W-1:0] thr_q;

    // gateway and target wiring
    logic [N_SRC:0]                pend, infl, gw_claim, gw_done;
    logic [N_CTX-1:0][ID_W-1:0]    best_id;

    logic            claim_rd, done_wr, done_ok;
    logic [ID_W-1:0] claim_id, done_id;

    assign claim_rd = rd_acc && req.region == REG_CLAIM && ctx_hit;
    assign claim_id = best_id[cidx];
    assign done_wr  = wr_acc && req.region == REG_CLAIM && ctx_hit;
    assign done_id  = req.wdata[ID_W-1:0];
    assign done_ok  = done_wr && (req.wdata != '0)
                      && (req.wdata <= DATA_W'(N_SRC)) && en_q[cidx][done_id];

    assign pend[0]     = 1'b0;
    assign infl[0]     = 1'b0;
    assign gw_claim[0] = 1'b0;
    assign gw_done[0]  = 1'b0;

    for (genvar s = 1; s <= N_SRC; s++) begin : g_src
        assign gw_claim[s] = claim_rd && claim_id == ID_W'(s);
        assign gw_done[s]  = done_ok && done_id == ID_W'(s);

        plic_gateway #(.QCNT_W(QCNT_W)) u_gw (
            .clk     (clk),
            .rst     (rst),
            .src_i   (src_i[s]),
            .mode_i  (mode_q[s]),
            .claim_i (gw_claim[s]),
            .done_i  (gw_done[s]),
            .pend_o  (pend[s]),
            .infl_o  (infl[s])
        );
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        plic_target #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tgt (
            .prio_i (prio_q),
            .pend_i (pend),
            .en_i   (en_q[c]),
            .thr_i  (thr_q[c]),
            .id_o   (best_id[c]),
            .irq_o  (irq_o[c])
        );
    end

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            mode_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr_acc) begin
            case (req.region)
                REG_PRIO:   if (src_hit) prio_q[sidx] <= req.wdata[PRIO_W-1:0];
                REG_MODE:   if (src_hit) mode_q[sidx] <= src_mode_t'(req.wdata[1:0]);
                REG_ENABLE: if (ctx_hit) en_q[cidx]   <= {req.wdata[N_SRC:1], 1'b0};
                REG_THRESH: if (ctx_hit) thr_q[cidx]  <= req.wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // read data
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (req.region)
            REG_PRIO:   if (src_hit) rd_mux[PRIO_W-1:0] = prio_q[sidx];
            REG_MODE:   if (src_hit) rd_mux[1:0]        = mode_q[sidx];
            REG_ENABLE: if (ctx_hit) rd_mux[N_SRC:0]    = en_q[cidx];
            REG_THRESH: if (ctx_hit) rd_mux[PRIO_W-1:0] = thr_q[cidx];
            REG_CLAIM:  if (ctx_hit) rd_mux[ID_W-1:0]   = claim_id;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= rd_acc;
            if (rd_acc) rsp_rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
    parameter int N_SRC  = 8,
    parameter int N_CTX  = 2,
    parameter int PRIO_W = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid_i,
    input logic                        req_write_i,
    input logic                        rsp_valid_o,
    input logic [N_CTX-1:0]            irq_o,
    input logic [N_SRC:0]              pend,
    input logic [N_SRC:0]              infl,
    input logic [N_SRC:0]              gw_claim,
    input logic [N_SRC:0][PRIO_W-1:0]  prio_q,
    input logic [N_CTX-1:0][N_SRC:0]   en_q
);
    assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);

    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

    assert_one_claim_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gw_claim));

    for (genvar s = 1; s <= N_SRC; s++) begin : g_s
        assert_claim_blocks_R6: assert property (@(posedge clk) disable iff (rst)
            gw_claim[s] |=> (infl[s] && !pend[s]));

        assert_pend_excl_R6: assert property (@(posedge clk) disable iff (rst)
            !(pend[s] && infl[s]));

        assert_prio_zero_R4: assert property (@(posedge clk) disable iff (rst)
            gw_claim[s] |-> (prio_q[s] != '0));
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_c
        assert_irq_cause_R3: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] |-> ((pend & en_q[c]) != '0));
    end

endmodule

bind plic_core plic_core_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .rsp_valid_o (rsp_valid_o),
    .irq_o       (irq_o),
    .pend        (pend),
    .infl        (infl),
    .gw_claim    (gw_claim),
    .prio_q      (prio_q),
    .en_q        (en_q)
);

// File: tb/plic_core_bench.sv
`timescale 1ns/1ps
module plic_core_bench;
    localparam int NS = 8;
    localparam int NC = 2;
    localparam int QMAX = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS:1]   src = '0;
    logic [NC-1:0] irq;
    logic          req_valid = 1'b0, req_write = 1'b0, req_ready;
    logic [19:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    plic_core u_plic_core (
        .clk(clk), .rst(rst), .src_i(src), .irq_o(irq),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_prio[NS+1], m_mode[NS+1], m_pend[NS+1], m_fl[NS+1], m_cnt[NS+1], m_srcq[NS+1];
    int m_en[NC], m_thr[NC];
    bit m_rsp_v;
    int m_rsp_d;

    function automatic int m_best(input int c);
        int bp = 0, bi = 0;
        for (int s = 1; s <= NS; s++)
            if (m_pend[s] != 0 && ((m_en[c] >> s) & 1) != 0 && m_prio[s] > bp) begin
                bp = m_prio[s];
                bi = s;
            end
        return bi;
    endfunction

    function automatic bit m_line(input int c);
        int b = m_best(c);
        return (b != 0) && (m_prio[b] > m_thr[c]);
    endfunction

    always @(posedge clk) begin : model
        int rg, ix, wd, cl, cp, p, f, q, e, n;
        if (rst) begin
            for (int s = 0; s <= NS; s++) begin
                m_prio[s] = 0; m_mode[s] = 0; m_pend[s] = 0;
                m_fl[s] = 0; m_cnt[s] = 0; m_srcq[s] = 0;
            end
            for (int c = 0; c < NC; c++) begin m_en[c] = 0; m_thr[c] = 0; end
            m_rsp_v = 0;
            m_rsp_d = 0;
        end else begin
            rg = int'(req_addr[19:16]);
            ix = int'(req_addr[15:0]);
            wd = int'(req_wdata);
            cl = 0;
            cp = 0;
            m_rsp_v = req_valid && !req_write;
            if (m_rsp_v) begin
                n = 0;
                case (rg)
                    0: if (ix >= 1 && ix <= NS) n = m_prio[ix];
                    1: if (ix >= 1 && ix <= NS) n = m_mode[ix];
                    2: if (ix < NC) n = m_en[ix];
                    3: if (ix < NC) n = m_thr[ix];
                    4: if (ix < NC) begin n = m_best(ix); cl = n; end
                    default: n = 0;
                endcase
                m_rsp_d = n;
            end
            if (req_valid && req_write && rg == 4 && ix < NC && wd >= 1 && wd <= NS
                && ((m_en[ix] >> wd) & 1) != 0)
                cp = wd;
            for (int s = 1; s <= NS; s++) begin
                p = m_pend[s]; f = m_fl[s]; n = m_cnt[s];
                e = m_mode[s] & 1; q = (m_mode[s] >> 1) & 1;
                if (cl == s) begin p = 0; f = 1; end
                else if (cp == s && f != 0) begin
                    f = 0;
                    if (e != 0 && q != 0 && n > 0) begin p = 1; n--; end
                end
                if (e == 0) begin
                    if (src[s] && p == 0 && f == 0) p = 1;
                end else if (src[s] && m_srcq[s] == 0) begin
                    if (p == 0 && f == 0) p = 1;
                    else if (f != 0 && q != 0 && n < QMAX) n++;
                end
                m_pend[s] = p; m_fl[s] = f; m_cnt[s] = n;
                m_srcq[s] = src[s] ? 1 : 0;
            end
            if (req_valid && req_write) begin
                case (rg)
                    0: if (ix >= 1 && ix <= NS) m_prio[ix] = wd & 7;
                    1: if (ix >= 1 && ix <= NS) m_mode[ix] = wd & 3;
                    2: if (ix < NC) m_en[ix] = wd & ((1 << (NS + 1)) - 1) & ~1;
                    3: if (ix < NC) m_thr[ix] = wd & 7;
                    default: ;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [NC-1:0] mi;
            for (int c = 0; c < NC; c++) mi[c] = m_line(c);
            check(irq === mi, "R3 R10 line vs model", irq, mi);
            check(rsp_valid === m_rsp_v, "R2 response valid vs model", rsp_valid, m_rsp_v);
            if (m_rsp_v) check(rsp_rdata === 32'(m_rsp_d), "R2 read data vs model", rsp_rdata, m_rsp_d);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input int rg, input int ix, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = {rg[3:0], ix[15:0]}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int rg, input int ix, input int exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = {rg[3:0], ix[15:0]};
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_rdata === 32'(exp), tag, rsp_rdata, exp);
    endtask

    task automatic set_src(input int mask);
        @(negedge clk);
        src = mask[NS:1];
        @(negedge clk);
    endtask

    task automatic pulse(input int mask);
        @(negedge clk);
        src = mask[NS:1];
        @(negedge clk);
        src = '0;
    endtask

    task automatic chk_irq(input logic [NC-1:0] exp, input string tag);
        @(negedge clk);
        check(irq === exp, tag, irq, exp);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        fork
            begin : main
                repeat (4) @(negedge clk);
                rst = 1'b0;
                chk_irq(2'b00, "R1 lines low after reset");
                rd(0, 1, 0, "R1 priority reads 0");
                rd(2, 0, 0, "R1 enable reads 0");
                rd(4, 0, 0, "R1 claim returns 0");

                wr(0, 1, 3); wr(0, 2, 5); wr(0, 3, 5); wr(0, 4, 0); wr(0, 5, 2);
                wr(3, 0, 1); wr(3, 1, 4);
                wr(2, 0, 32'h3F); wr(2, 1, 32'h0C);
                rd(0, 2, 5, "R2 priority readback");
                rd(2, 0, 32'h3E, "R2 enable bit 0 reads 0");
                rd(3, 1, 4, "R2 threshold readback");

                set_src(32'h3E);
                chk_irq(2'b11, "R3 R10 level sources raise both lines");
                rd(4, 0, 2, "R5 tie picks lowest ID");
                rd(4, 0, 3, "R5 second of tied pair");
                chk_irq(2'b01, "R10 claimed sources withheld from other target");
                rd(4, 1, 0, "R6 claimed sources not claimable");
                rd(4, 0, 1, "R5 next priority");
                rd(4, 0, 5, "R5 lowest nonzero priority");
                rd(4, 0, 0, "R4 priority 0 never claimed");
                chk_irq(2'b00, "R4 R6 no line while all claimed");

                wr(4, 1, 1);
                rd(4, 0, 0, "R7 completion from non-enabling target ignored");
                wr(4, 0, 9);
                wr(4, 0, 1);
                rd(4, 0, 1, "R6 level source re-pends after completion");

                set_src(32'h04);
                wr(4, 0, 1); wr(4, 0, 2); wr(4, 0, 3); wr(4, 0, 5);
                chk_irq(2'b11, "R3 priority 5 above both thresholds");
                wr(0, 2, 4);
                chk_irq(2'b01, "R4 priority equal to threshold masked");
                rd(4, 1, 2, "R5 claim not limited by threshold");
                chk_irq(2'b00, "R6 line drops after claim");
                wr(4, 1, 2);
                chk_irq(2'b01, "R6 completion re-pends held level");
                set_src(0);
                rd(4, 0, 2, "R5 claim held source");
                wr(4, 0, 2);
                chk_irq(2'b00, "R3 no sources left");

                wr(2, 0, 32'hC0); wr(2, 1, 0);
                wr(0, 6, 1); wr(0, 7, 1);
                wr(1, 6, 3); wr(1, 7, 1);
                rd(1, 6, 3, "R2 mode readback");
                pulse(32'hC0);
                rd(4, 0, 6, "R5 edge tie lowest ID");
                rd(4, 0, 7, "R5 edge second");
                for (int k = 0; k < 4; k++) pulse(32'h40);
                pulse(32'h80); pulse(32'h80);
                chk_irq(2'b00, "R8 R9 edges during claim raise nothing");
                wr(4, 0, 7);
                rd(4, 0, 0, "R9 ignored edges not replayed");
                for (int k = 0; k < QMAX; k++) begin
                    wr(4, 0, 6);
                    rd(4, 0, 6, "R8 queued edge replayed");
                end
                wr(4, 0, 6);
                rd(4, 0, 0, "R8 queue saturates at its maximum");
                chk_irq(2'b00, "R8 idle after drain");
            end
            begin : watchdog
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R1 watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule